// File: doc/BRIEF.md
# Byte-Wide Configuration Download Host

This block loads a configuration image into a programmable target device over a byte-wide slave parallel port. Bytes arrive from an upstream source through a valid/ready handshake, and the final byte carries a last flag. A start pulse launches an attempt. The controller first pulls the active-low program line for a fixed number of system cycles. It then waits for the target's init line to read High. After that it lowers chip select and read/write together and clocks each byte out on a divided configuration clock.

The target captures data on the rising configuration-clock edge. When the busy check is enabled, the controller samples the target's busy line in the last system cycle of each clock-high phase. If busy is High there, it keeps the same byte on the bus for one more full clock period. After the last byte has been taken, the clock keeps running so the target can finish its start-up sequence. The attempt ends in one of three ways: done rises (success), init falls at any point after the first byte request (init error), or too many clock periods pass without done (timeout). The three-state result stays on the status outputs until the next start.

State machine (states): IDLE, PROG (program pulse), WAIT (waiting for init High), FETCH (requesting a byte), SEND (clocking a byte), FLUSH (start-up clocks after the data). Transitions:
- IDLE→PROG on start.
- PROG→WAIT after PROG_CYCLES cycles.
- WAIT→FETCH when init reads High.
- FETCH→SEND on a source handshake.
- SEND→FETCH when a non-last byte is accepted.
- SEND→FLUSH when the last byte is accepted.
- FLUSH→IDLE on done (success) or on timeout.
- FETCH/SEND/FLUSH→IDLE when init is Low (init error).

Top module: `cfg_loader`

## Requirements
- R1: The mode-select output `mode_sel` is always the binary value 110, which picks byte-wide slave parallel loading.
- R2: After reset, `prog_low`=0, `cs_n`=1, `rdwr_n`=1, `cclk`=0, `src_ready`=0, `dout`=0 and all three status outputs are 0.
- R3: A start pulse seen in IDLE drives `prog_low` High for exactly PROG_CYCLES consecutive cycles, beginning the cycle after start. A start pulse seen in any other state has no effect.
- R4: After the program pulse, `cs_n` stays High and no byte is requested until `init_in` reads High.
- R5: `cs_n` and `rdwr_n` are Low together in FETCH, SEND and FLUSH, and High in every other state.
- R6: While a byte is being clocked, and during FLUSH, `cclk` has a period of CCLK_DIV system cycles: Low for the first half, High for the second. From the second cycle outside SEND/FLUSH it is Low.
- R7: `src_ready` is High only in FETCH while `init_in` is High. Each handshake loads one byte onto `dout`, which changes only while `cclk` is Low. Bytes are presented in source order.
- R8: If `busy_in` is High in the last system cycle of a `cclk` High phase (with USE_BUSY=1), the same byte is clocked again for another full period.
- R9: After the byte with `src_last`=1 is accepted, `cclk` keeps running until `done_in` is High. The controller then sets `done_ok` and returns to IDLE, raising `cs_n`/`rdwr_n` in the next cycle.
- R10: `init_in` Low in FETCH, SEND or FLUSH ends the attempt with `err_init`=1.
- R11: If TIMEOUT_CLKS `cclk` periods complete in FLUSH without `done_in`, the attempt ends with `err_timeout`=1.
- R12: At most one status output is High. Status holds in IDLE and clears in the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration attempt (honoured in IDLE) |
| src_data | input | DATA_W | Image byte from the source |
| src_valid | input | 1 | Source byte is valid |
| src_last | input | 1 | Current source byte is the final one |
| src_ready | output | 1 | Controller takes the source byte this cycle |
| prog_low | output | 1 | Drive-enable pulling the program line Low |
| init_in | input | 1 | Sampled init line from the target |
| done_in | input | 1 | Sampled done line from the target |
| busy_in | input | 1 | Busy line from the target |
| cs_n | output | 1 | Active-low chip select |
| rdwr_n | output | 1 | Read/write select, Low for write |
| cclk | output | 1 | Configuration clock |
| dout | output | DATA_W | Configuration data bus |
| mode_sel | output | 3 | Mode strap value for the target |
| done_ok | output | 1 | Last attempt succeeded |
| err_init | output | 1 | Last attempt ended on init Low |
| err_timeout | output | 1 | Last attempt timed out waiting for done |

## Verification
The assertions assume `init_in`, `done_in` and `busy_in` are already synchronous to `clk`. They also assume busy changes only in response to a rising `cclk`, so one value covers a whole High phase. The bench models the target behaviourally and drives those three lines at falling system-clock edges. It changes busy only on the cycle it sees a new rising `cclk`, and it drops init only after a chosen number of accepted bytes. The source queue is driven the same way, with optional gaps in `src_valid`. This keeps every handshake input stable across the edge that samples it.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    // Mode strap value selecting byte-wide slave parallel loading.
    localparam logic [2:0] MODE_BYTE_SLAVE = 3'b110;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PROG  = 3'd1,
        S_WAIT  = 3'd2,
        S_FETCH = 3'd3,
        S_SEND  = 3'd4,
        S_FLUSH = 3'd5
    } cfgl_state_e;

endpackage

// File: rtl/cfgl_clkdiv.sv
module cfgl_clkdiv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic cclk,
    output logic fall_stb
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] CNT_MID  = CW'(DIV / 2 - 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // fall_stb marks the last cycle of a High phase: cclk drops at the next edge.
    assign fall_stb = en && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cclk  <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            cclk  <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            cclk  <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_MID) begin
                cclk <= 1'b1;
            end
        end
    end

    // R6: a Low-to-High cclk transition only follows an enabled cycle
    a_r6_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk) |-> $past(en));

endmodule

// File: rtl/cfgl_wdog.sv
module cfgl_wdog #(
    parameter int LIMIT = 1 << 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic expire
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] CNT_END = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_q;

    assign expire = en && tick && (cnt_q == CNT_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
    import cfgl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 16,
    parameter int USE_BUSY    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              init_in,
    input  logic              done_in,
    input  logic              busy_in,
    input  logic              fall_stb,
    input  logic              tmo_expire,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_valid,
    input  logic              src_last,
    output logic              src_ready,
    output logic              prog_low,
    output logic              sel_n,
    output logic              rdwr_n,
    output logic              clk_en,
    output logic              wd_en,
    output logic [DATA_W-1:0] dout,
    output logic              done_ok,
    output logic              err_init,
    output logic              err_timeout
);
    localparam int PW = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYCLES - 1);
    localparam bit HONOUR_BUSY = (USE_BUSY != 0);

    cfgl_state_e state_q, state_d;
    logic [PW-1:0] pcnt_q;
    logic          last_q;
    logic          hold;
    logic          take;
    logic          in_xfer;

    assign hold    = HONOUR_BUSY && busy_in;
    assign take    = (state_q == S_FETCH) && init_in && src_valid;
    assign in_xfer = (state_q == S_FETCH) || (state_q == S_SEND) || (state_q == S_FLUSH);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = S_PROG;
            end
            S_PROG: begin
                if (pcnt_q == PROG_LAST) state_d = S_WAIT;
            end
            S_WAIT: begin
                if (init_in) state_d = S_FETCH;
            end
            S_FETCH: begin
                if (!init_in)       state_d = S_IDLE;
                else if (src_valid) state_d = S_SEND;
            end
            S_SEND: begin
                if (!init_in)                state_d = S_IDLE;
                else if (fall_stb && !hold)  state_d = last_q ? S_FLUSH : S_FETCH;
            end
            S_FLUSH: begin
                if (!init_in)        state_d = S_IDLE;
                else if (done_in)    state_d = S_IDLE;
                else if (tmo_expire) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        prog_low  = 1'b0;
        sel_n     = 1'b1;
        rdwr_n    = 1'b1;
        src_ready = 1'b0;
        clk_en    = 1'b0;
        wd_en     = 1'b0;
        unique case (state_q)
            S_PROG: prog_low = 1'b1;
            S_FETCH: begin
                sel_n     = 1'b0;
                rdwr_n    = 1'b0;
                src_ready = init_in;
            end
            S_SEND: begin
                sel_n  = 1'b0;
                rdwr_n = 1'b0;
                clk_en = 1'b1;
            end
            S_FLUSH: begin
                sel_n  = 1'b0;
                rdwr_n = 1'b0;
                clk_en = 1'b1;
                wd_en  = 1'b1;
            end
            default: ;
        endcase
    end

    // Pulse counter, byte register and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q      <= '0;
            last_q      <= 1'b0;
            dout        <= '0;
            done_ok     <= 1'b0;
            err_init    <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start) begin
                pcnt_q      <= '0;
                done_ok     <= 1'b0;
                err_init    <= 1'b0;
                err_timeout <= 1'b0;
            end
            if (state_q == S_PROG && pcnt_q != PROG_LAST) begin
                pcnt_q <= pcnt_q + 1'b1;
            end
            if (take) begin
                dout   <= src_data;
                last_q <= src_last;
            end
            if (in_xfer && !init_in) begin
                err_init <= 1'b1;
            end
            if (state_q == S_FLUSH && init_in && done_in) begin
                done_ok <= 1'b1;
            end
            if (state_q == S_FLUSH && init_in && !done_in && tmo_expire) begin
                err_timeout <= 1'b1;
            end
        end
    end

    // R3: the program pulse only begins after a start request
    a_r3_pulse_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_low) |-> $past(start));

    // R10: an init error is only flagged after init was sampled Low
    a_r10_err_after_init_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_init) |-> !$past(init_in));

    // R12: result outputs are mutually exclusive
    a_r12_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_ok, err_init, err_timeout}));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfgl_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int CCLK_DIV     = 4,
    parameter int PROG_CYCLES  = 16,
    parameter int TIMEOUT_CLKS = 1 << 20,
    parameter int USE_BUSY     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_valid,
    input  logic              src_last,
    output logic              src_ready,
    output logic              prog_low,
    input  logic              init_in,
    input  logic              done_in,
    input  logic              busy_in,
    output logic              cs_n,
    output logic              rdwr_n,
    output logic              cclk,
    output logic [DATA_W-1:0] dout,
    output logic [2:0]        mode_sel,
    output logic              done_ok,
    output logic              err_init,
    output logic              err_timeout
);
    logic clk_en;
    logic wd_en;
    logic fall_stb;
    logic tmo_expire;

    assign mode_sel = MODE_BYTE_SLAVE;

    cfgl_clkdiv #(
        .DIV (CCLK_DIV)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (clk_en),
        .cclk     (cclk),
        .fall_stb (fall_stb)
    );

    cfgl_wdog #(
        .LIMIT (TIMEOUT_CLKS)
    ) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (wd_en),
        .tick   (fall_stb),
        .expire (tmo_expire)
    );

    cfgl_seq #(
        .DATA_W      (DATA_W),
        .PROG_CYCLES (PROG_CYCLES),
        .USE_BUSY    (USE_BUSY)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .init_in     (init_in),
        .done_in     (done_in),
        .busy_in     (busy_in),
        .fall_stb    (fall_stb),
        .tmo_expire  (tmo_expire),
        .src_data    (src_data),
        .src_valid   (src_valid),
        .src_last    (src_last),
        .src_ready   (src_ready),
        .prog_low    (prog_low),
        .sel_n       (cs_n),
        .rdwr_n      (rdwr_n),
        .clk_en      (clk_en),
        .wd_en       (wd_en),
        .dout        (dout),
        .done_ok     (done_ok),
        .err_init    (err_init),
        .err_timeout (err_timeout)
    );

    // R7: the data bus holds its value across every rising cclk edge
    a_r7_bus_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk) |-> $stable(dout));

    // R4: chip select only falls once init has been seen High
    a_r4_select_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(init_in));

    // R6: with the port deselected for two cycles the clock is parked Low
    a_r6_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !cclk);

endmodule

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
    localparam int DIV  = 4;
    localparam int PROG = 16;
    localparam int TMO  = 12;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] src_data = '0;
    logic       src_valid = 1'b0;
    logic       src_last = 1'b0;
    logic       init_in = 1'b1;
    logic       done_in = 1'b0;
    logic       busy_in = 1'b0;
    logic       src_ready, prog_low, cs_n, rdwr_n, cclk;
    logic [7:0] dout;
    logic [2:0] mode_sel;
    logic       done_ok, err_init, err_timeout;

    cfg_loader #(
        .DATA_W(8), .CCLK_DIV(DIV), .PROG_CYCLES(PROG),
        .TIMEOUT_CLKS(TMO), .USE_BUSY(1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_data(src_data), .src_valid(src_valid), .src_last(src_last),
        .src_ready(src_ready), .prog_low(prog_low), .init_in(init_in),
        .done_in(done_in), .busy_in(busy_in), .cs_n(cs_n), .rdwr_n(rdwr_n),
        .cclk(cclk), .dout(dout), .mode_sel(mode_sel), .done_ok(done_ok),
        .err_init(err_init), .err_timeout(err_timeout)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // ms: 0 idle, 1 program pulse, 2 wait init, 3 fetch, 4 send, 5 flush
    int ms = 0, mcnt = 0, mp = 0, mt = 0;
    logic [7:0] mdout = '0;
    bit mlast = 0, mok = 0, mei = 0, met = 0;
    bit m_fall, m_fire;
    int m_next;
    logic [7:0] srcq[$];
    logic [7:0] txlog[$];
    logic [7:0] rxlog[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mcnt = 0; mp = 0; mt = 0; mdout = '0;
            mlast = 0; mok = 0; mei = 0; met = 0;
        end else begin
            m_fall = (ms == 4 || ms == 5) && mcnt == DIV - 1;
            m_fire = (ms == 3) && init_in && src_valid;
            m_next = ms;
            case (ms)
                0: if (start) begin m_next = 1; mp = 0; mok = 0; mei = 0; met = 0; end
                1: if (mp == PROG - 1) m_next = 2; else mp++;
                2: if (init_in) m_next = 3;
                3: if (!init_in) begin m_next = 0; mei = 1; end
                   else if (m_fire) begin
                       mdout = src_data; mlast = src_last;
                       void'(srcq.pop_front());
                       m_next = 4;
                   end
                4: if (!init_in) begin m_next = 0; mei = 1; end
                   else if (m_fall && !busy_in) m_next = mlast ? 5 : 3;
                5: if (!init_in) begin m_next = 0; mei = 1; end
                   else if (done_in) begin m_next = 0; mok = 1; end
                   else if (m_fall && mt == TMO - 1) begin m_next = 0; met = 1; end
                default: m_next = 0;
            endcase
            if (ms == 5) begin
                if (m_fall) mt++;
            end else mt = 0;
            if (ms == 4 || ms == 5) mcnt = (mcnt + 1) % DIV;
            else mcnt = 0;
            ms = m_next;
        end
    end

    // ---------------- target model, source and per-cycle compare ----------------
    int cfg_init_delay = 3, cfg_drop = -1, cfg_done = 4;
    bit cfg_busy = 0, cfg_gap = 0;
    int cyc = 0, icnt = 0, rise_idx = 0, frises = 0;
    bit dropped = 0, prev_cclk = 0, rise;
    bit compare_on = 0;

    always @(negedge clk) begin
        if (compare_on) begin
            chk(prog_low == (ms == 1), "R3 prog_low", prog_low, ms == 1);
            chk(cs_n == !(ms >= 3), "R4 R5 cs_n", cs_n, !(ms >= 3));
            chk(rdwr_n == !(ms >= 3), "R5 rdwr_n", rdwr_n, !(ms >= 3));
            chk(cclk == (mcnt >= DIV / 2), "R6 cclk", cclk, mcnt >= DIV / 2);
            chk(dout == mdout, "R7 dout", dout, mdout);
            chk(src_ready == (ms == 3 && init_in), "R7 src_ready", src_ready, ms == 3 && init_in);
            chk(done_ok == mok, "R9 done_ok", done_ok, mok);
            chk(err_init == mei, "R10 err_init", err_init, mei);
            chk(err_timeout == met, "R11 err_timeout", err_timeout, met);
            chk(mode_sel == 3'b110, "R1 mode_sel", mode_sel, 3'b110);
        end
        cyc++;
        // init behaviour of the target
        if (prog_low) begin
            init_in = 0; done_in = 0; busy_in = 0;
            icnt = 0; dropped = 0; rise_idx = 0; frises = 0;
        end else if (!init_in && !dropped) begin
            icnt++;
            if (icnt >= cfg_init_delay) init_in = 1;
        end
        // capture on rising cclk, drive busy and done
        rise = cclk && !prev_cclk;
        prev_cclk = cclk;
        if (rise && !cs_n) begin
            if (rxlog.size() < txlog.size()) begin
                busy_in = cfg_busy && (rise_idx % 3 == 1);
                rise_idx++;
                if (!busy_in) rxlog.push_back(dout);
            end else begin
                busy_in = 0;
                frises++;
                if (cfg_done >= 0 && frises >= cfg_done) done_in = 1;
            end
        end
        if (cfg_drop >= 0 && !dropped && init_in && rxlog.size() >= cfg_drop) begin
            init_in = 0; dropped = 1;
        end
        // byte source
        src_valid = (srcq.size() > 0) && !(cfg_gap && (cyc % 3 == 0));
        src_data  = (srcq.size() > 0) ? srcq[0] : 8'h00;
        src_last  = (srcq.size() == 1);
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic run(input int n, input bit gap, input bit busy, input int idly,
                       input int drop, input int dn, input int mid_start, input int seed);
        srcq.delete(); txlog.delete(); rxlog.delete();
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'((seed * 37 + i * 29 + 5) & 8'hFF);
            srcq.push_back(b);
            txlog.push_back(b);
        end
        cfg_gap = gap; cfg_busy = busy; cfg_init_delay = idly;
        cfg_drop = drop; cfg_done = dn;
        pulse_start();
        // R12: status cleared right after an accepted start
        chk(!done_ok && !err_init && !err_timeout, "R12 cleared on start",
            {done_ok, err_init, err_timeout}, 0);
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (k == mid_start) begin
                start = 1;
                @(negedge clk);
                start = 0;
            end
            if (ms == 0 && (mok || mei || met)) break;
        end
        repeat (8) @(negedge clk);
        srcq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        chk(!prog_low && cs_n && rdwr_n && !cclk && !src_ready && dout == 0,
            "R2 reset outputs", {prog_low, cs_n, rdwr_n, cclk, src_ready}, 5'b01100);
        chk(!done_ok && !err_init && !err_timeout, "R2 reset status",
            {done_ok, err_init, err_timeout}, 0);
        rst_n = 1;
        compare_on = 1;
        repeat (4) @(negedge clk);

        // plain run: 6 bytes, no gaps, no busy
        run(6, 0, 0, 5, -1, 4, -1, 1);
        chk(done_ok == 1, "R9 success flagged", done_ok, 1);
        chk(rxlog.size() == 6 && rxlog == txlog, "R7 bytes in order", rxlog.size(), 6);

        // R12: result holds while idle
        repeat (20) @(negedge clk);
        chk(done_ok == 1 && cs_n == 1, "R12 status held", done_ok, 1);

        // gaps, busy stalls, a late start pulse that must be ignored
        run(8, 1, 1, 2, -1, 10, 30, 2);
        chk(done_ok == 1, "R9 success with stalls", done_ok, 1);
        chk(rxlog == txlog, "R7 order under busy", rxlog.size(), txlog.size());
        chk(rise_idx > 8, "R8 busy repeats a byte", rise_idx, 9);

        // init drops after 3 accepted bytes
        run(8, 0, 0, 4, 3, 4, -1, 3);
        chk(err_init == 1 && done_ok == 0, "R10 init low error", err_init, 1);
        chk(cs_n == 1 && rdwr_n == 1 && cclk == 0, "R10 port released", {cs_n, rdwr_n, cclk}, 3'b110);

        // done never rises
        run(3, 0, 0, 1, -1, -1, -1, 4);
        chk(err_timeout == 1 && err_init == 0, "R11 timeout error", err_timeout, 1);
        chk(frises >= TMO, "R11 clocks before timeout", frises, TMO);

        // short image of one byte, then status clears on the next start
        run(1, 0, 1, 1, -1, 2, -1, 5);
        chk(done_ok == 1 && err_timeout == 0, "R12 new result replaces old", done_ok, 1);
        chk(rxlog == txlog, "R7 single byte", rxlog.size(), 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule